// File: doc/BRIEF.md
# Multi-lane SPI result serializer

This block is the target-side output shifter of a converter that hands a 20-bit result to a host over a serial link. The host owns the chip select and the serial clock. The block samples both with its own system clock, finds their edges and drives one, two or four data lanes. The result word, the protocol code and the lane width are all latched when chip select falls. After that the host may change these inputs freely until the frame ends.

The two bits of the protocol code set the idle level of the serial clock and the edge on which the host captures data. The low bit sets when the first data appears. A code with a clear low bit presents the MSB as soon as chip select falls. A code with a set low bit keeps the lanes low until the first launch edge, and that edge presents the MSB without shifting. Every later launch edge advances the word by one, two or four bits.

A host may raise chip select early and keep only the upper bits. In single-lane mode a frame that runs past the word becomes a daisy-chain path: bits captured from the serial input follow the word out. The frame state machine has four states:
- IDLE: chip select is high and all lanes are low.
- ARMED: a late-launch protocol is waiting for its first launch edge.
- SHIFT: data is on the lanes.
- DRAIN: a multi-lane word is used up and the lanes are low.

Its transitions are:
- IDLE to SHIFT on a chip-select fall with an early-launch code.
- IDLE to ARMED on a chip-select fall with a late-launch code.
- ARMED to SHIFT on the first launch edge.
- SHIFT to DRAIN on the launch edge that uses up a multi-lane word.
- Any state to IDLE whenever chip select is high.

Top module: `lane_spi_serializer`

## Requirements
- R1: While chip select is high, and from reset, all four lanes drive 0. One system clock after chip select rises, every lane is 0.
- R2: Protocol codes 00 and 10 put the MSB on the lanes one system clock after chip select falls. Each later launch edge presents the next bits. The launch edge is falling for code 00 and rising for code 10.
- R3: Protocol codes 01 and 11 keep all lanes at 0 after chip select falls. The first launch edge then presents the MSB without shifting. The launch edge is rising for code 01 and falling for code 11.
- R4: In single-lane mode, lane 0 carries the word MSB first. Presentation i shows word bit 19-i, for i from 0 to 19.
- R5: Lane-width code 10 sends two bits per launch edge on lanes 1 and 0, with lane 1 carrying the higher bit. Presentation i shows bits 19-2i and 18-2i. From the tenth presentation onward, both lanes are 0.
- R6: Lane-width code 11 sends four bits per launch edge, with lane 3 carrying the highest bit. Presentation i shows bits 19-4i down to 16-4i. From the fifth presentation onward, all lanes are 0.
- R7: Lane-width codes 00 and 01 select single-lane mode, and lanes 3 to 1 stay 0 in that mode.
- R8: In single-lane mode, lane 0 at presentation i (i at least 20) shows the serial input. The value shown is the one sampled at capture edge i-19, with capture edges counted from the first one after the MSB is presented.
- R9: Raising chip select at any point ends the frame. The next frame starts from the MSB of the newly latched word.
- R10: The word, protocol code and lane width are taken only at the chip-select fall. Changes to them during a frame have no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial input for daisy-chain pass-through |
| result_word | input | WORD_W | Word to send, latched at chip-select fall |
| proto_sel | input | 2 | Protocol code: bit 1 is the clock idle level, bit 0 selects late launch |
| lane_sel | input | 2 | Lane width code: 10 dual, 11 quad, others single |
| sdo | output | MAX_LANES | Output lanes, lane 0 is the single-lane output |

## Verification
Directed frames cover each protocol code in single-lane mode, which separates early launch from late launch and rising launch edges from falling ones. Dual-lane and quad-lane frames run past the end of the word, which shows lane ordering and when the lanes drop to 0. A long single-lane frame fed with random serial-input bits shows that the daisy-chain delay is exactly one word. A truncated frame, a frame whose inputs change mid-flight, and seeded random frames with random codes, words and lengths separate latching from live sampling and check that every frame restarts cleanly.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DRAIN = 2'd3
    } ser_state_t;

    // number of active lanes for a lane-width code
    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        unique case (code)
            2'b10:   lanes_of = 3'd2;
            2'b11:   lanes_of = 3'd4;
            default: lanes_of = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/ser_edge_det.sv
module ser_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_fall_o
);
    logic sclk_q;
    logic cs_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            cs_n_q <= cs_n_i;
        end
    end

    assign sclk_rise_o = sclk_i & ~sclk_q;
    assign sclk_fall_o = ~sclk_i & sclk_q;
    assign cs_fall_o   = ~cs_n_i & cs_n_q;

endmodule

// File: rtl/ser_lane_mux.sv
module ser_lane_mux #(
    parameter int LANES = 4
) (
    input  logic             en_i,
    input  logic [2:0]       lane_cnt_i,
    input  logic [LANES-1:0] top_bits_i,
    output logic [LANES-1:0] sdo_o
);
    // with n lanes, lane l shows top bit (LANES - n + l); higher lane = higher bit
    always_comb begin
        sdo_o = '0;
        if (en_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (l < int'(lane_cnt_i)) begin
                    sdo_o[l] = top_bits_i[LANES - int'(lane_cnt_i) + l];
                end
            end
        end
    end

endmodule

// File: rtl/lane_spi_serializer.sv
module lane_spi_serializer
    import spi_ser_pkg::*;
#(
    parameter int WORD_W    = 20,
    parameter int MAX_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic [WORD_W-1:0]    result_word,
    input  logic [1:0]           proto_sel,
    input  logic [1:0]           lane_sel,
    output logic [MAX_LANES-1:0] sdo
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LIM_DUAL = CNT_W'(WORD_W / 2);
    localparam logic [CNT_W-1:0] LIM_QUAD = CNT_W'(WORD_W / 4);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    ser_state_t        state_q, state_d;
    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sdi_cap_q;
    logic [1:0]        proto_q;
    logic [1:0]        width_q;

    logic sclk_rise, sclk_fall, cs_fall;
    logic launch_edge, capture_edge;
    logic [2:0] lane_cnt;
    logic [CNT_W-1:0] limit;
    logic multi;

    ser_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .sclk_rise_o(sclk_rise),
        .sclk_fall_o(sclk_fall),
        .cs_fall_o  (cs_fall)
    );

    // codes 01 and 10 launch on rising edges, 00 and 11 on falling edges
    assign launch_edge  = (proto_q[1] ^ proto_q[0]) ? sclk_rise : sclk_fall;
    assign capture_edge = (proto_q[1] ^ proto_q[0]) ? sclk_fall : sclk_rise;
    assign lane_cnt     = lanes_of(width_q);
    assign multi        = (lane_cnt != 3'd1);

    always_comb begin
        unique case (lane_cnt)
            3'd2:    limit = LIM_DUAL;
            3'd4:    limit = LIM_QUAD;
            default: limit = CNT_MAX;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = proto_sel[0] ? ST_ARMED : ST_SHIFT;
            ST_ARMED: if (launch_edge) state_d = ST_SHIFT;
            ST_SHIFT: if (launch_edge && multi && (cnt_q + 1'b1 == limit)) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_DRAIN;
        endcase
        if (cs_n) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q    <= '0;
            cnt_q     <= '0;
            sdi_cap_q <= 1'b0;
            proto_q   <= 2'b00;
            width_q   <= 2'b00;
        end else if (cs_n) begin
            cnt_q     <= '0;
            sdi_cap_q <= 1'b0;
        end else if (state_q == ST_IDLE && cs_fall) begin
            sreg_q    <= result_word;
            proto_q   <= proto_sel;
            width_q   <= lane_sel;
            cnt_q     <= '0;
            sdi_cap_q <= 1'b0;
        end else if (state_q == ST_SHIFT) begin
            if (capture_edge) sdi_cap_q <= sdi;
            if (launch_edge) begin
                unique case (lane_cnt)
                    3'd2:    sreg_q <= sreg_q << 2;
                    3'd4:    sreg_q <= sreg_q << 4;
                    default: sreg_q <= {sreg_q[WORD_W-2:0], sdi_cap_q};
                endcase
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // output process
    ser_lane_mux #(.LANES(MAX_LANES)) u_mux (
        .en_i      (state_q == ST_SHIFT),
        .lane_cnt_i(lane_cnt),
        .top_bits_i(sreg_q[WORD_W-1 -: MAX_LANES]),
        .sdo_o     (sdo)
    );

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (sdo == '0)); // R1
    AST_EARLY_MSB: assert property (@(posedge clk) disable iff (!rst_n) (cs_fall && !proto_sel[0] && lanes_of(lane_sel) == 3'd1) |=> (sdo[0] == $past(result_word[WORD_W-1]))); // R2
    AST_LATE_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (cs_fall && proto_sel[0]) |=> (sdo == '0)); // R3
    AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_IDLE && lane_cnt == 3'd1) |-> (sdo[MAX_LANES-1:1] == '0)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_SHIFT && multi) |-> (cnt_q < limit)); // R5

endmodule

// File: tb/lane_spi_serializer_tb_top.sv
`timescale 1ns/1ps
module lane_spi_serializer_tb_top;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [19:0] result_word = '0;
    logic [1:0] proto_sel = 2'b00, lane_sel = 2'b00;
    logic [3:0] sdo;

    int checks = 0, fails = 0;
    logic hist [0:63];

    always #2.5 clk = ~clk;

    lane_spi_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .result_word(result_word), .proto_sel(proto_sel), .lane_sel(lane_sel), .sdo(sdo)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sdo=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lanes_f(input logic [1:0] w);
        return (w == 2'b10) ? 2 : (w == 2'b11) ? 4 : 1;
    endfunction

    function automatic logic [3:0] exp_sdo(input logic [19:0] w, input logic [1:0] ls, input int idx);
        int n = lanes_f(ls);
        logic [3:0] e = '0;
        if (idx < 20 / n) begin
            for (int l = 0; l < n; l++) e[l] = w[19 - idx * n - (n - 1 - l)];
        end else if (n == 1) begin
            e[0] = hist[idx - 19];
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [1:0] ls, input int idx);
        int n = lanes_f(ls);
        if (n == 2) return "R5";
        if (n == 4) return "R6";
        if (idx >= 20) return "R8";
        if (ls == 2'b01) return "R7";
        return "R4";
    endfunction

    task automatic run_frame(input logic [19:0] w, input logic [1:0] p, input logic [1:0] ls,
                             input int nlaunch, input bit mid_change, input string force_tag);
        bit launch_rise = p[1] ^ p[0];
        int launches = 0, ncap = 0, idx;
        string t;
        cs_n = 1'b1; sclk = p[1]; result_word = w; proto_sel = p; lane_sel = ls;
        for (int i = 0; i < 64; i++) hist[i] = 1'b0;
        tick(H);
        cs_n = 1'b0;
        tick(H);
        if (!p[0]) check((force_tag != "") ? force_tag : "R2", sdo, exp_sdo(w, ls, 0));
        else       check("R3", sdo, 4'b0000);
        if (mid_change) begin
            result_word = ~w; lane_sel = ~ls; proto_sel = ~p;
        end
        while (launches < nlaunch) begin
            logic nv = ~sclk;
            bit is_launch = (nv == launch_rise);
            if (!is_launch) begin
                sdi = 1'($urandom);
                ncap++;
                if (ncap < 64) hist[ncap] = sdi;
            end
            sclk = nv;
            tick(H);
            if (is_launch) begin
                launches++;
                idx = p[0] ? launches - 1 : launches;
                t = mid_change ? "R10" : (force_tag != "") ? force_tag : tag_of(ls, idx);
                if (p[0] && launches == 1 && !mid_change && force_tag == "") t = "R3";
                check(t, sdo, exp_sdo(w, ls, idx));
            end
        end
        cs_n = 1'b1;
        tick(2);
        check("R1", sdo, 4'b0000);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: sdo=%b expected frame end", sdo);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        tick(5);
        check("R1", sdo, 4'b0000);
        rst_n = 1'b1;
        tick(3);
        check("R1", sdo, 4'b0000);
        // each protocol, single lane, full word
        run_frame(20'hA5C3E, 2'b00, 2'b00, 20, 1'b0, "");
        run_frame(20'h5A3C1, 2'b01, 2'b00, 20, 1'b0, "");
        run_frame(20'hF0F0F, 2'b10, 2'b00, 19, 1'b0, "");
        run_frame(20'h12345, 2'b11, 2'b00, 21, 1'b0, "");
        // daisy chain past the word
        run_frame(20'h80001, 2'b00, 2'b00, 30, 1'b0, "");
        run_frame(20'h7FFFE, 2'b11, 2'b01, 28, 1'b0, "");
        // dual and quad, running past the end
        run_frame(20'hC3A59, 2'b00, 2'b10, 12, 1'b0, "");
        run_frame(20'h96E1B, 2'b01, 2'b10, 12, 1'b0, "");
        run_frame(20'hDEADB, 2'b11, 2'b11, 7, 1'b0, "");
        run_frame(20'h3C5A7, 2'b10, 2'b11, 7, 1'b0, "");
        // truncated frame, then clean restart (R9)
        run_frame(20'hFFFFF, 2'b00, 2'b00, 6, 1'b0, "R9");
        run_frame(20'h00F0F, 2'b00, 2'b00, 20, 1'b0, "R9");
        run_frame(20'hABCDE, 2'b00, 2'b11, 2, 1'b0, "R9");
        run_frame(20'h13579, 2'b01, 2'b00, 20, 1'b0, "R9");
        // inputs changed mid-frame (R10)
        run_frame(20'h2468A, 2'b00, 2'b00, 20, 1'b1, "");
        run_frame(20'hBEEF1, 2'b11, 2'b10, 11, 1'b1, "");
        // seeded random frames
        for (int k = 0; k < 24; k++) begin
            logic [19:0] w = 20'($urandom);
            logic [1:0] p = 2'($urandom);
            logic [1:0] ls = 2'($urandom);
            int n = lanes_f(ls);
            int len = 1 + int'($urandom % ((n == 1) ? 32 : (20 / n + 3)));
            run_frame(w, p, ls, len, 1'b0, "");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule